// File: doc/BRIEF.md
# Supply-Fault Reset Pulse Generator

This block turns the digital results of a supply monitor into a processor reset. It takes a low-line flag from an external comparator, a flag saying the supply has dropped below the backup battery, and a one-cycle strobe from a watchdog timer. It drives an active-low reset and its active-high complement. Reset stays asserted while either supply fault is present and for a fixed number of timebase ticks after both clear. A watchdog strobe produces a pulse of the same width. Repeated supply dropouts keep reset asserted, because every new low-line event restarts the full hold time.

The hold counter advances only on cycles where the `tick` enable is high. The tick comes from a nominal 10.24 kHz timebase or from an external clock, so the default of 512 ticks gives about 50 ms. The block also drives a low-line status output with no added hold time. It gates an active-low RAM chip enable, forcing it inactive during any supply fault so that no write reaches backed-up memory. A one-cycle end-of-reset strobe lets the watchdog restart its timer.

The three asynchronous control inputs are the low-line flag, the backup flag and the chip-enable input. Each passes through a two-flop synchronizer before use. The watchdog strobe and the tick come from the block's own clock domain.

Top module: `supply_reset_gen`

## Requirements
- R1: While the synchronized low-line flag or backup flag is 1, `rst_n_out` is 0. A change on `lowline_in` or `backup_in` reaches `rst_n_out` on the third rising clock edge after it is sampled.
- R2: Once both fault flags are clear, `rst_n_out` stays 0 until HOLD_TICKS clock edges with `tick`=1 have passed. Edges with `tick`=0 do not count. With `tick` held at 1, reset releases on edge 515 after the input clears.
- R3: A `wdt_req`=1 sampled while reset is released drives `rst_n_out` to 0 on that edge. Reset then releases HOLD_TICKS ticked edges later, which is edge 513 from the request when `tick` stays 1.
- R4: `rst_out` is always the logical inverse of `rst_n_out`.
- R5: `lowline_n_out` is 0 exactly while the synchronized low-line flag is 1, two edges after `lowline_in`, with no hold time. `backup_in` has no effect on it.
- R6: `ce_out_n` (0 = enabled) equals the synchronized `ce_in_n` while neither fault flag is set. Otherwise it is forced to 1. This gating does not depend on the reset hold.
- R7: A new low-line event during the hold restarts the full hold. `rst_n_out` stays 0 across repeated dropouts and releases HOLD_TICKS ticks after the last one clears.
- R8: A `wdt_req` that arrives while reset is already asserted is ignored and does not extend the release time.
- R9: `reset_done` is 1 for exactly one cycle, on the cycle in which `rst_n_out` returns to 1.
- R10: During `rst`=1 the outputs are `rst_n_out`=0, `rst_out`=1, `lowline_n_out`=1, `ce_out_n`=1 and `reset_done`=0. After `rst` falls, a full hold runs, and reset releases on the 512th edge when `tick` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable, one cycle per hold-counter step |
| lowline_in | input | 1 | Asynchronous low-line comparator flag, 1 = supply low |
| backup_in | input | 1 | Asynchronous flag, 1 = supply below battery |
| ce_in_n | input | 1 | Asynchronous active-low chip-enable request |
| wdt_req | input | 1 | One-cycle watchdog timeout strobe |
| rst_n_out | output | 1 | Active-low processor reset |
| rst_out | output | 1 | Active-high processor reset |
| lowline_n_out | output | 1 | Low-line status, 0 while supply is low |
| ce_out_n | output | 1 | Gated active-low chip enable |
| reset_done | output | 1 | One-cycle strobe at reset release |

## Verification
The main function is driven with a single long low-line event, a backup-only fault, and a watchdog strobe from the released state, and the release edge is checked in each case. The backup-only fault separates the reset path from the status path, since only reset and chip-enable may react to it. A watchdog strobe sent during an existing hold, a `tick` gap, and a train of short dropouts separate the cases of ignoring, pausing and restarting the hold counter. Each of these predicts a different release cycle.

// File: rtl/supply_rst_pkg.sv
package supply_rst_pkg;

    localparam int SYNC_STAGES_DEF = 2;
    localparam int HOLD_TICKS_DEF  = 512;

    typedef enum logic [1:0] {
        ST_FAULT = 2'd0,
        ST_HOLD  = 2'd1,
        ST_RUN   = 2'd2
    } rst_state_e;

    typedef struct packed {
        logic lowline;
        logic backup;
        logic ce_n;
    } ctl_in_t;

    localparam int CTL_W = $bits(ctl_in_t);
    localparam ctl_in_t CTL_IDLE = '{lowline: 1'b0, backup: 1'b0, ce_n: 1'b1};

    function automatic logic supply_fault(input ctl_in_t c);
        return c.lowline | c.backup;
    endfunction

endpackage

// File: rtl/sig_sync_bank.sv
module sig_sync_bank #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= IDLE_VAL;
        else     stg[0] <= d_async;
    end

    genvar s;
    generate
        for (s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= IDLE_VAL;
                else     stg[s] <= stg[s-1];
            end
        end
    endgenerate

    assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/rst_hold_fsm.sv
module rst_hold_fsm
    import supply_rst_pkg::*;
#(
    parameter int HOLD_TICKS = HOLD_TICKS_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fault_s,
    input  logic wdt_req,
    output logic released,
    output logic done
);
    localparam int CNT_W = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD_TICKS - 1);

    rst_state_e       st;
    logic [CNT_W-1:0] cnt;
    logic             done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_HOLD;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (fault_s) begin
                st  <= ST_FAULT;
                cnt <= '0;
            end else begin
                unique case (st)
                    ST_FAULT: begin
                        st  <= ST_HOLD;
                        cnt <= '0;
                    end
                    ST_HOLD: begin
                        if (tick) begin
                            if (cnt == CNT_LAST) begin
                                st     <= ST_RUN;
                                cnt    <= '0;
                                done_q <= 1'b1;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RUN: begin
                        if (wdt_req) begin
                            st  <= ST_HOLD;
                            cnt <= '0;
                        end
                    end
                    default: begin
                        st  <= ST_HOLD;
                        cnt <= '0;
                    end
                endcase
            end
        end
    end

    assign released = (st == ST_RUN);
    assign done     = done_q;

    // R3: a request while released starts a fresh hold
    assert_wdt_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN && wdt_req && !fault_s) |=> (st == ST_HOLD && cnt == '0));

    // R2: release only leaves a fault-free, ticked hold
    assert_release_from_hold_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(released) |-> $past(st == ST_HOLD && !fault_s && tick));

    // R9: end strobe lasts one cycle
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: a request during a hold leaves the count advancing
    assert_wdt_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && !fault_s && tick && cnt != CNT_LAST) |=> (cnt != '0));
endmodule

// File: rtl/ce_write_gate.sv
module ce_write_gate (
    input  logic ce_n_s,
    input  logic fault_s,
    output logic ce_out_n
);
    assign ce_out_n = ce_n_s | fault_s;
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen
    import supply_rst_pkg::*;
#(
    parameter int HOLD_TICKS  = HOLD_TICKS_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic lowline_in,
    input  logic backup_in,
    input  logic ce_in_n,
    input  logic wdt_req,
    output logic rst_n_out,
    output logic rst_out,
    output logic lowline_n_out,
    output logic ce_out_n,
    output logic reset_done
);
    ctl_in_t ctl_raw, ctl_s;
    logic    fault_s;
    logic    released;

    assign ctl_raw = '{lowline: lowline_in, backup: backup_in, ce_n: ce_in_n};

    sig_sync_bank #(
        .WIDTH   (CTL_W),
        .STAGES  (SYNC_STAGES),
        .IDLE_VAL(CTL_IDLE)
    ) u_sync (
        .clk    (clk),
        .rst    (rst),
        .d_async(ctl_raw),
        .q_sync (ctl_s)
    );

    assign fault_s = supply_fault(ctl_s);

    rst_hold_fsm #(
        .HOLD_TICKS(HOLD_TICKS)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .fault_s (fault_s),
        .wdt_req (wdt_req),
        .released(released),
        .done    (reset_done)
    );

    ce_write_gate u_gate (
        .ce_n_s  (ctl_s.ce_n),
        .fault_s (fault_s),
        .ce_out_n(ce_out_n)
    );

    assign rst_n_out     = released;
    assign rst_out       = ~released;
    assign lowline_n_out = ~ctl_s.lowline;

    // R1: a synchronized fault forces reset on the next edge
    assert_fault_resets_R1: assert property (@(posedge clk) disable iff (rst)
        fault_s |=> !rst_n_out);

    // R5: low-line status low implies reset follows
    assert_status_before_reset_R5: assert property (@(posedge clk) disable iff (rst)
        !lowline_n_out |=> rst_out);

    // R6: while the reset machine is in a fault, writes stay blocked
    assert_ce_blocked_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(fault_s) && fault_s) |-> ce_out_n);
endmodule

// File: tb/tb_supply_reset_gen.sv
module tb_supply_reset_gen;
    localparam time CLK_PERIOD = 10ns;
    localparam int  LIMIT      = 20000;

    localparam int SIG_RSTN = 0;
    localparam int SIG_RST  = 1;
    localparam int SIG_LLN  = 2;
    localparam int SIG_CEN  = 3;
    localparam int SIG_DONE = 4;

    typedef struct {
        int    cyc;
        int    sig;
        logic  val;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic lowline_in = 1'b0;
    logic backup_in = 1'b0;
    logic ce_in_n = 1'b1;
    logic wdt_req = 1'b0;
    logic rst_n_out, rst_out, lowline_n_out, ce_out_n, reset_done;

    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   reported = 0;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    supply_reset_gen dut (
        .clk(clk), .rst(rst), .tick(tick),
        .lowline_in(lowline_in), .backup_in(backup_in),
        .ce_in_n(ce_in_n), .wdt_req(wdt_req),
        .rst_n_out(rst_n_out), .rst_out(rst_out),
        .lowline_n_out(lowline_n_out), .ce_out_n(ce_out_n),
        .reset_done(reset_done)
    );

    function automatic logic pick(int sig);
        case (sig)
            SIG_RSTN: return rst_n_out;
            SIG_RST:  return rst_out;
            SIG_LLN:  return lowline_n_out;
            SIG_CEN:  return ce_out_n;
            default:  return reset_done;
        endcase
    endfunction

    task automatic expect_at(int c, int sig, logic v, string tag);
        exp_t e;
        e.cyc = c; e.sig = sig; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // monitor: compare queued expectations, plus R4 on every cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].cyc == cyc) begin
                logic got;
                got = pick(q[i].sig);
                checks++;
                if (got !== q[i].val) begin
                    failures++;
                    $display("FAIL %s cyc=%0d sig=%0d actual=%b expected=%b",
                             q[i].tag, cyc, q[i].sig, got, q[i].val);
                end
                q.delete(i);
            end
        end
        checks++;
        if (rst_out !== ~rst_n_out) begin
            failures++;
            $display("FAIL R4 cyc=%0d actual rst_out=%b expected=%b", cyc, rst_out, ~rst_n_out);
        end
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        int k;
        // R10: reset state and power-on hold
        step(2);
        k = cyc;
        expect_at(k+1, SIG_RSTN, 1'b0, "R10");
        expect_at(k+1, SIG_RST,  1'b1, "R10");
        expect_at(k+1, SIG_LLN,  1'b1, "R10");
        expect_at(k+1, SIG_CEN,  1'b1, "R10");
        expect_at(k+1, SIG_DONE, 1'b0, "R10");
        step(1);
        k = cyc;
        rst = 1'b0;
        expect_at(k+511, SIG_RSTN, 1'b0, "R10");
        expect_at(k+512, SIG_RSTN, 1'b1, "R10");
        expect_at(k+512, SIG_DONE, 1'b1, "R9");
        expect_at(k+513, SIG_DONE, 1'b0, "R9");
        step(520);

        // R6: chip enable follows the input when no fault
        k = cyc;
        ce_in_n = 1'b0;
        expect_at(k+1, SIG_CEN, 1'b1, "R6");
        expect_at(k+2, SIG_CEN, 1'b0, "R6");
        step(5);

        // R1 R5 R6 R2: one long low-line event, watchdog during fault (R8)
        k = cyc;
        lowline_in = 1'b1;
        expect_at(k+1, SIG_LLN,  1'b1, "R5");
        expect_at(k+2, SIG_LLN,  1'b0, "R5");
        expect_at(k+2, SIG_RSTN, 1'b1, "R1");
        expect_at(k+3, SIG_RSTN, 1'b0, "R1");
        expect_at(k+3, SIG_CEN,  1'b1, "R6");
        step(10);
        wdt_req = 1'b1;
        step(1);
        wdt_req = 1'b0;
        step(9);
        k = cyc;
        lowline_in = 1'b0;
        expect_at(k+1,   SIG_LLN,  1'b0, "R5");
        expect_at(k+1,   SIG_CEN,  1'b1, "R6");
        expect_at(k+2,   SIG_LLN,  1'b1, "R5");
        expect_at(k+2,   SIG_CEN,  1'b0, "R6");
        expect_at(k+514, SIG_RSTN, 1'b0, "R2");
        expect_at(k+515, SIG_RSTN, 1'b1, "R2");
        expect_at(k+515, SIG_DONE, 1'b1, "R9");
        step(520);

        // backup-only fault: reset and CE react, status does not (R5)
        k = cyc;
        backup_in = 1'b1;
        expect_at(k+3, SIG_RSTN, 1'b0, "R1");
        expect_at(k+3, SIG_CEN,  1'b1, "R6");
        expect_at(k+5, SIG_LLN,  1'b1, "R5");
        step(15);
        k = cyc;
        backup_in = 1'b0;
        expect_at(k+514, SIG_RSTN, 1'b0, "R2");
        expect_at(k+515, SIG_RSTN, 1'b1, "R2");
        step(520);

        // R3 and R8: watchdog pulse, second request during hold ignored
        k = cyc;
        wdt_req = 1'b1;
        expect_at(k,     SIG_RSTN, 1'b1, "R3");
        expect_at(k+1,   SIG_RSTN, 1'b0, "R3");
        expect_at(k+1,   SIG_RST,  1'b1, "R4");
        expect_at(k+512, SIG_RSTN, 1'b0, "R8");
        expect_at(k+513, SIG_RSTN, 1'b1, "R3");
        expect_at(k+513, SIG_DONE, 1'b1, "R9");
        expect_at(k+514, SIG_DONE, 1'b0, "R9");
        step(1);
        wdt_req = 1'b0;
        step(199);
        wdt_req = 1'b1;
        step(1);
        wdt_req = 1'b0;
        step(330);

        // R2: edges without tick do not count
        k = cyc;
        wdt_req = 1'b1;
        tick = 1'b0;
        step(1);
        wdt_req = 1'b0;
        step(99);
        tick = 1'b1;
        expect_at(k+513, SIG_RSTN, 1'b0, "R2");
        expect_at(k+611, SIG_RSTN, 1'b0, "R2");
        expect_at(k+612, SIG_RSTN, 1'b1, "R2");
        step(520);

        // R7: repeated dropouts restart the hold
        k = cyc;
        lowline_in = 1'b1;
        expect_at(k+3, SIG_RSTN, 1'b0, "R7");
        step(5);   lowline_in = 1'b0;
        step(100); lowline_in = 1'b1;
        step(3);   lowline_in = 1'b0;
        expect_at(k+200, SIG_RSTN, 1'b0, "R7");
        expect_at(k+303, SIG_LLN,  1'b0, "R5");
        expect_at(k+304, SIG_LLN,  1'b1, "R5");
        expect_at(k+400, SIG_RSTN, 1'b0, "R7");
        expect_at(k+623, SIG_RSTN, 1'b0, "R7");
        expect_at(k+816, SIG_RSTN, 1'b0, "R7");
        expect_at(k+817, SIG_RSTN, 1'b1, "R7");
        step(192); lowline_in = 1'b1;
        step(2);   lowline_in = 1'b0;
        step(530);

        if (q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard actual=%0d pending expected=0", q.size());
        end
        summary();
    end
endmodule